// File: doc/BRIEF.md
# IF Chain Offset Trim Sequencer

This block runs the power-on DC offset trim of a three-stage IF amplifier chain that has I and Q branches. It visits every gain word in turn, from the lowest to the highest. Within each gain word it trims the I branch and then the Q branch. Within each branch it trims stage 0, then stage 1, then stage 2. For the stage under trim it loads a 6-bit correction code and enables the comparator for one fixed time slot. It then reads the comparator's sign and moves the code by one step in the direction that reduces the offset. It stops as soon as the sign reverses, or when the code cannot move any further.

Each final code is written to an internal lookup table. The same write is also driven on output ports, so a table elsewhere can take a copy. Normal receive logic reads the table back by address once the sweep has finished. While a later stage is being trimmed, the earlier stages of the same branch keep the codes they were just given. This way, each stage cancels only its own residue.

Top module: `ifdc_trim_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, the outputs `cmp_en_o`, `wr_en_o`, `done_o`, `busy_o` and `stage_en_o` are all zero.
- R2: A `start_i` pulse in idle or done writes exactly one table entry for each (gain, branch, stage). The order is gain ascending, then branch I (0) before Q (1), then stage 0, 1, 2. The write address is {gain, branch, stage}, with the stage in the two lowest bits and the branch in the bit above them.
- R3: Each stage's trim begins at code 32 with `gain_o` and `branch_q_o` set to its gain and branch. `stage_en_o` is thermometer-coded (bits 0..s set while stage s is trimmed). `dac_code_o` carries stage k's code in bits [6k+5:6k].
- R4: `cmp_en_o` is high for exactly SLOT_CYC consecutive cycles per comparison, and `cmp_i` is sampled in the last of them. Two comparisons are separated by at least two cycles with `cmp_en_o` low.
- R5: `cmp_i`=1 lowers the code by one and `cmp_i`=0 raises it by one. The first sample that differs from the previous sample ends the stage. The code under test when that reversed sample was taken is the code stored.
- R6: If the code is 0 with `cmp_i`=1, or 63 with `cmp_i`=0, that boundary code is stored and `sat_o` is set. `sat_o` then stays set until the next start.
- R7: While stage s is trimmed, stages below s hold the codes stored for them in this gain and branch, and stages above s hold 32.
- R8: `dac_code_o` is stable while `cmp_en_o` is high.
- R9: After the last write, `done_o` is high and stays high until the next start. While `done_o` is high, `busy_o`, `cmp_en_o` and `wr_en_o` are low and `stage_en_o` is zero.
- R10: `rd_data_o` returns the stored code of `rd_addr_i` one clock later.
- R11: `start_i` while busy has no effect.
- R12: A new start after done clears `sat_o`, sweeps again and overwrites the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a full trim sweep |
| cmp_i | input | 1 | Comparator sign, 1 = offset positive |
| rd_addr_i | input | GAIN_W+3 | Table read address {gain, branch, stage} |
| gain_o | output | GAIN_W | Gain word applied to the chain |
| branch_q_o | output | 1 | Branch under trim, 1 = Q |
| stage_en_o | output | 3 | Stage enables, thermometer |
| dac_code_o | output | 18 | Correction codes for the three stages |
| cmp_en_o | output | 1 | Comparator enable |
| wr_en_o | output | 1 | Table write strobe |
| wr_addr_o | output | GAIN_W+3 | Table write address |
| wr_data_o | output | 6 | Table write code |
| rd_data_o | output | 6 | Table read data |
| sat_o | output | 1 | A stage hit a code limit |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Sweep finished |

## Verification
The assertions assume that `cmp_i` only matters in the last cycle of a slot. They also assume that `start_i` is a single-cycle pulse, and that the block alone drives the DAC codes, so nothing else moves them during a slot. The bench's comparator model is a per-address threshold. It is driven to the wrong sign whenever `cmp_en_o` is low, so any sample taken outside the slot is caught. Its thresholds are chosen to cover reversals in both directions and saturation at both ends. Two sweeps with different thresholds show that restarting, clearing saturation and overwriting the table all work.

// File: rtl/ifdc_pkg.sv
package ifdc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SLOT,
    ST_DECIDE,
    ST_NEXT,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/ifdc_slot_timer.sv
module ifdc_slot_timer #(
  parameter int SLOT_CYC = 240,
  localparam int CNT_W = $clog2(SLOT_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic last_o
);
  logic [CNT_W-1:0] cnt;

  assign last_o = run_i && (cnt == CNT_W'(SLOT_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !run_i || last_o) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(SLOT_CYC));
endmodule

// File: rtl/ifdc_step_judge.sv
module ifdc_step_judge #(
  parameter int CODE_W = 6
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              sign_i,
  input  logic              prev_i,
  input  logic              first_i,
  output logic              stop_o,
  output logic              sat_o,
  output logic [CODE_W-1:0] next_o
);
  localparam logic [CODE_W-1:0] CMAX = '1;
  logic flip, at_lo, at_hi;

  always_comb begin
    flip   = !first_i && (sign_i != prev_i);
    at_lo  = sign_i && (code_i == '0);
    at_hi  = !sign_i && (code_i == CMAX);
    stop_o = flip || at_lo || at_hi;
    sat_o  = !flip && (at_lo || at_hi);
    next_o = sign_i ? code_i - 1'b1 : code_i + 1'b1;
  end
endmodule

// File: rtl/ifdc_trim_ram.sv
module ifdc_trim_ram #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 6,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/ifdc_trim_seq.sv
module ifdc_trim_seq #(
  parameter int N_GAIN   = 61,
  parameter int GAIN_W   = 6,
  parameter int CODE_W   = 6,
  parameter int N_STAGE  = 3,
  parameter int SLOT_CYC = 240,
  localparam int STG_W   = 2,
  localparam int ADDR_W  = GAIN_W + 1 + STG_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic                      cmp_i,
  input  logic [ADDR_W-1:0]         rd_addr_i,
  output logic [GAIN_W-1:0]         gain_o,
  output logic                      branch_q_o,
  output logic [N_STAGE-1:0]        stage_en_o,
  output logic [N_STAGE*CODE_W-1:0] dac_code_o,
  output logic                      cmp_en_o,
  output logic                      wr_en_o,
  output logic [ADDR_W-1:0]         wr_addr_o,
  output logic [CODE_W-1:0]         wr_data_o,
  output logic [CODE_W-1:0]         rd_data_o,
  output logic                      sat_o,
  output logic                      busy_o,
  output logic                      done_o
);
  import ifdc_pkg::*;

  localparam logic [CODE_W-1:0] MID = CODE_W'(1 << (CODE_W - 1));

  seq_state_t        state;
  logic [GAIN_W-1:0] gain;
  logic              branch;
  logic [STG_W-1:0]  stage;
  logic [CODE_W-1:0] codes [N_STAGE];
  logic              smp, prev_sign, first;
  logic              slot_last;
  logic              stop_w, sat_w;
  logic [CODE_W-1:0] next_w, act_code;
  logic              go;

  assign act_code = codes[stage];
  assign busy_o   = (state != ST_IDLE) && (state != ST_DONE);
  assign cmp_en_o = (state == ST_SLOT);
  assign gain_o   = gain;
  assign branch_q_o = branch;
  assign go       = start_i && !busy_o;

  genvar k;
  generate
    for (k = 0; k < N_STAGE; k++) begin : g_stage
      assign dac_code_o[k*CODE_W +: CODE_W] = codes[k];
      assign stage_en_o[k] = busy_o && (STG_W'(k) <= stage);
    end
  endgenerate

  ifdc_slot_timer #(.SLOT_CYC(SLOT_CYC)) i_timer (
    .clk    (clk),
    .rst    (rst),
    .run_i  (cmp_en_o),
    .last_o (slot_last)
  );

  ifdc_step_judge #(.CODE_W(CODE_W)) i_judge (
    .code_i  (act_code),
    .sign_i  (smp),
    .prev_i  (prev_sign),
    .first_i (first),
    .stop_o  (stop_w),
    .sat_o   (sat_w),
    .next_o  (next_w)
  );

  ifdc_trim_ram #(.ADDR_W(ADDR_W), .DATA_W(CODE_W)) i_ram (
    .clk     (clk),
    .we_i    (wr_en_o),
    .waddr_i (wr_addr_o),
    .wdata_i (wr_data_o),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      gain      <= '0;
      branch    <= 1'b0;
      stage     <= '0;
      smp       <= 1'b0;
      prev_sign <= 1'b0;
      first     <= 1'b1;
      sat_o     <= 1'b0;
      done_o    <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      for (int i = 0; i < N_STAGE; i++) codes[i] <= MID;
    end else begin
      wr_en_o <= 1'b0;
      case (state)
        ST_IDLE, ST_DONE: begin
          if (go) begin
            gain   <= '0;
            branch <= 1'b0;
            stage  <= '0;
            first  <= 1'b1;
            sat_o  <= 1'b0;
            done_o <= 1'b0;
            for (int i = 0; i < N_STAGE; i++) codes[i] <= MID;
            state  <= ST_SETUP;
          end
        end
        ST_SETUP: state <= ST_SLOT;
        ST_SLOT: begin
          if (slot_last) begin
            smp   <= cmp_i;
            state <= ST_DECIDE;
          end
        end
        ST_DECIDE: begin
          if (stop_w) begin
            wr_en_o   <= 1'b1;
            wr_addr_o <= {gain, branch, stage};
            wr_data_o <= act_code;
            if (sat_w) sat_o <= 1'b1;
            state     <= ST_NEXT;
          end else begin
            codes[stage] <= next_w;
            prev_sign    <= smp;
            first        <= 1'b0;
            state        <= ST_SETUP;
          end
        end
        ST_NEXT: begin
          first <= 1'b1;
          state <= ST_SETUP;
          if (stage == STG_W'(N_STAGE - 1)) begin
            stage <= '0;
            for (int i = 0; i < N_STAGE; i++) codes[i] <= MID;
            if (branch) begin
              branch <= 1'b0;
              if (gain == GAIN_W'(N_GAIN - 1)) begin
                done_o <= 1'b1;
                state  <= ST_DONE;
              end else begin
                gain <= gain + 1'b1;
              end
            end else begin
              branch <= 1'b1;
            end
          end else begin
            stage <= stage + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  cmp_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cmp_en_o) |=> !cmp_en_o);

  // R8
  dac_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_en_o |=> ($stable(dac_code_o) || !cmp_en_o));

  // R5
  step_unit_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECIDE && !stop_w) |=>
      ((act_code == $past(act_code) + CODE_W'(1)) ||
       (act_code == $past(act_code) - CODE_W'(1))));

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!cmp_en_o && !wr_en_o && stage_en_o == '0 && !busy_o));

  // R2
  wr_busy_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (busy_o && !cmp_en_o));

  // R6
  sat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (sat_o && !go) |=> sat_o);
endmodule

// File: tb/test_ifdc_trim_seq.sv
module test_ifdc_trim_seq;
  localparam int NG = 4;
  localparam int GW = 2;
  localparam int CW = 6;
  localparam int NS = 3;
  localparam int SC = 4;
  localparam int AW = GW + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cmp;
  logic [AW-1:0] rd_addr = '0;
  logic [GW-1:0] gain;
  logic branch;
  logic [NS-1:0] stage_en;
  logic [NS*CW-1:0] dac;
  logic cmp_en, wr_en, sat, busy, done;
  logic [AW-1:0] wr_addr;
  logic [CW-1:0] wr_data, rd_data;

  int checks = 0, fails = 0;
  int phase = 0;
  int widx = 0;
  bit fresh = 1'b1;
  int run_hi = 0, run_lo = 0;
  bit seen_slot = 1'b0;
  bit last_model = 1'b0;
  int prev_act = 0;
  bit monitor_on = 1'b0;
  logic [NS*CW-1:0] prev_dac = '0;
  bit prev_cmp_en = 1'b0;
  int act_s;

  always #10 clk = ~clk;

  ifdc_trim_seq #(.N_GAIN(NG), .GAIN_W(GW), .CODE_W(CW), .N_STAGE(NS), .SLOT_CYC(SC)) i_ifdc_trim_seq (
    .clk(clk), .rst(rst), .start_i(start), .cmp_i(cmp), .rd_addr_i(rd_addr),
    .gain_o(gain), .branch_q_o(branch), .stage_en_o(stage_en), .dac_code_o(dac),
    .cmp_en_o(cmp_en), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_data_o(rd_data), .sat_o(sat), .busy_o(busy), .done_o(done)
  );

  function automatic int tgt(int g, int b, int s, int ph);
    return ((g * 7 + b * 13 + s * 5 + ph * 23) % 70) - 3;
  endfunction

  function automatic int exp_code(int g, int b, int s, int ph);
    int t;
    t = tgt(g, b, s, ph);
    if (t < 0) return 0;
    if (t < 32) return t;
    if (t <= 62) return t + 1;
    return 63;
  endfunction

  function automatic bit exp_sat(int g, int b, int s, int ph);
    int t;
    t = tgt(g, b, s, ph);
    return (t < 0) || (t > 62);
  endfunction

  always_comb begin
    act_s = 0;
    for (int k = 0; k < NS; k++) if (stage_en[k]) act_s = k;
  end

  logic model;
  assign model = int'(dac[act_s*CW +: CW]) > tgt(int'(gain), int'(branch), act_s, phase);
  assign cmp = cmp_en ? model : !model;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    if (monitor_on) begin
      int act;
      act = int'(dac[act_s*CW +: CW]);
      if (cmp_en) begin
        if (!prev_cmp_en) begin
          if (seen_slot) chk(run_lo >= 2, "R4 gap", run_lo, 2);
          if (fresh) begin
            chk(act == 32, "R3 start code", act, 32);
            chk(int'(gain) == widx / 6 && int'(branch) == (widx % 6) / 3 && act_s == widx % 3,
                "R3 position", int'(gain) * 8 + int'(branch) * 4 + act_s, widx);
            chk(stage_en == NS'((1 << (act_s + 1)) - 1), "R3 stage enables", int'(stage_en), (1 << (act_s + 1)) - 1);
            fresh = 1'b0;
          end else begin
            chk(act == (last_model ? prev_act - 1 : prev_act + 1), "R5 step", act,
                last_model ? prev_act - 1 : prev_act + 1);
          end
          for (int k = 0; k < NS; k++) begin
            int e;
            e = (k < act_s) ? exp_code(int'(gain), int'(branch), k, phase) : (k > act_s ? 32 : act);
            chk(int'(dac[k*CW +: CW]) == e, "R7 other stages", int'(dac[k*CW +: CW]), e);
          end
        end else begin
          chk(dac == prev_dac, "R8 stable codes", int'(dac), int'(prev_dac));
        end
        seen_slot = 1'b1;
        run_hi++;
        run_lo = 0;
        last_model = model;
        prev_act = act;
      end else begin
        if (run_hi > 0) chk(run_hi == SC, "R4 slot length", run_hi, SC);
        run_hi = 0;
        run_lo++;
      end
      if (wr_en) begin
        int g, b, s;
        g = widx / 6; b = (widx % 6) / 3; s = widx % 3;
        chk(int'(wr_addr) == g * 8 + b * 4 + s, "R2 write address", int'(wr_addr), g * 8 + b * 4 + s);
        chk(int'(wr_data) == exp_code(g, b, s, phase), exp_sat(g, b, s, phase) ? "R6 saturated code" : "R5 stored code",
            int'(wr_data), exp_code(g, b, s, phase));
        widx++;
        fresh = 1'b1;
        seen_slot = 1'b0;
      end
      prev_dac = dac;
      prev_cmp_en = cmp_en;
    end
  end

  task automatic sweep(int ph);
    bit any_sat;
    phase = ph;
    widx = 0;
    fresh = 1'b1;
    seen_slot = 1'b0;
    run_hi = 0;
    any_sat = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(sat == 1'b0, "R12 sat cleared", int'(sat), 0);
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    repeat (7) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done) @(negedge clk);
    chk(widx == NG * 6, "R11 write count", widx, NG * 6);
    for (int g = 0; g < NG; g++)
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < NS; s++)
          if (exp_sat(g, b, s, ph)) any_sat = 1'b1;
    chk(sat == any_sat, "R6 sat flag", int'(sat), int'(any_sat));
    repeat (5) @(negedge clk);
    chk(done && !busy && !cmp_en && stage_en == '0, "R9 done holds", int'(done), 1);
    for (int g = 0; g < NG; g++)
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < NS; s++) begin
          rd_addr = AW'(g * 8 + b * 4 + s);
          @(negedge clk);
          chk(int'(rd_data) == exp_code(g, b, s, ph), ph ? "R12 table rewritten" : "R10 readback",
              int'(rd_data), exp_code(g, b, s, ph));
        end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(!cmp_en && !wr_en && !done && !busy && stage_en == '0, "R1 reset outputs", int'(busy), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!cmp_en && !wr_en && !done && !busy && stage_en == '0, "R1 after reset", int'(cmp_en), 0);
    monitor_on = 1'b1;
    sweep(0);
    sweep(1);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule